// File: doc/BRIEF.md
# Sequenced SAR ADC Serial Host

This block is the host-side controller for a four-input successive-approximation converter on a three-wire serial link. The converter has a convert-start line and signals that a conversion is finished by pulling its data-out line low. A free-running rate divider paces conversions. On each rate tick the block raises the convert line for a fixed number of system clocks and then waits for the data line to go low. When it sees that, it clocks one frame of 17 serial clocks. Each frame sends a 14-bit configuration word and receives the 16-bit result of the conversion that has just finished, so reading and configuring both happen after the conversion and never late inside it.

The converter's internal sequencer scans inputs 0 to 3. Each configuration word takes effect two conversions after the frame that carries it. Because of this lag, the block throws away the first two frames after reset and then tags results 0, 1, 2, 3, 0 and so on. If the data line does not go low within a timeout, the block flags an error and drops that frame. It then treats the next two paced conversions as dummies, so the pipeline is back in step before results are presented again. Software can load a new configuration word at any time, and the next frame sends it.

Top module: `adc_scan_host`

## Requirements
- R1: After each rate tick (every CLK_HZ/(SAMPLE_HZ*NUM_CH) clocks), `adcCnv` goes high for exactly CNV_HIGH clocks, and then low.
- R2: `adcSck` stays low while `adcCnv` is high, and stays low after that until `adcSdo` has been seen low. `adcCnv` stays low during the frame.
- R3: A frame has exactly 17 rising edges of `adcSck`. `adcSdo` is sampled just before each falling edge. The first sample (the busy bit) is discarded, and the other 16 form `resData`, MSB first.
- R4: `adcDin` carries the configuration word MSB first. Its bits are valid at the first 14 rising edges of `adcSck`, and it is 0 for the last 3. The word after reset is {overwrite=1 [13], input mode [12:10] = 110 unipolar or 010 bipolar to COM, last channel=011 [9:7], quarter bandwidth=0 [6], reference=111 [5:3], sequencer=11 [2:1], readback off=0 [0]}. This is 14'h39BE in unipolar mode.
- R5: A one-cycle `cfgWr` pulse stores `cfgData`. Every later frame sends the stored word unchanged until the next write.
- R6: The first two frames after reset produce no `resValid` pulse. Every later frame produces exactly one pulse.
- R7: Valid results carry `resChan` tags 0, 1, 2, 3, 0, 1 and so on, one step per result.
- R8: Suppose `adcSdo` is not seen low within BUSY_TIMEOUT clocks after `adcCnv` falls. Then `timeoutErr` pulses for one cycle, no serial clocks are issued, the next two frames are discarded, and tags restart at 0.
- R9: During and just after reset, `adcCnv`, `adcSck`, `adcDin`, `resValid` and `timeoutErr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfgWr | input | 1 | Store `cfgData` as the word for following frames |
| cfgData | input | 14 | Configuration word to store |
| adcSdo | input | 1 | Converter data out (busy-low indicator, then result) |
| adcCnv | output | 1 | Convert-start pulse |
| adcSck | output | 1 | Serial clock, idles low |
| adcDin | output | 1 | Configuration data to converter |
| resValid | output | 1 | One-cycle result strobe |
| resData | output | 16 | Conversion result |
| resChan | output | 2 | Input channel of the result |
| timeoutErr | output | 1 | One-cycle pulse when busy-low never arrived |

## Verification
The assertions assume several things about the converter. It drives its data line high within one system clock of the convert line rising. It holds the line high until the conversion finishes. It changes the line only after falling serial-clock edges. The rate period is longer than a conversion plus a frame. The bench converter model drives the line high 1 ns after the convert edge. It holds the busy-low edge back by a random 4 to 33 clocks, well inside the 60-clock timeout, and updates the data bits 1 ns after each falling edge. The rate period is 200 clocks, which leaves room for the longest conversion plus a full frame. The timeout path is reached in only one way: the model deliberately never answers one conversion.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  localparam int CFG_W = 14;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CNV,
    ST_WAIT,
    ST_LOW,
    ST_HIGH
  } phase_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadCfg;    // busy-low seen: frame begins, take config word
    logic shiftOut;   // serial clock falls (not the last): next config bit
    logic sampleIn;   // end of high phase: capture data line
    logic frameDone;  // last sample of the frame
    logic resync;     // busy-low timeout: restart pipeline tracking
  } dpStrobe_t;

  function automatic logic [CFG_W-1:0] resetCfg(input logic bipolar, input logic [2:0] lastCh);
    return {1'b1, (bipolar ? 3'b010 : 3'b110), lastCh, 1'b0, 3'b111, 2'b11, 1'b0};
  endfunction

endpackage

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int RATE_DIV     = 78125,
  parameter int CNV_HIGH     = 3,
  parameter int SCK_HALF     = 3,
  parameter int BUSY_TIMEOUT = 2000,
  parameter int FRAME_LEN    = 17
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sdoIn,
  output logic      cnvOut,
  output logic      sckOut,
  output logic      sdoLvl,
  output logic      timeoutErr,
  output dpStrobe_t strb
);

  localparam int T1     = (CNV_HIGH > SCK_HALF) ? CNV_HIGH : SCK_HALF;
  localparam int TMAX   = (T1 > BUSY_TIMEOUT) ? T1 : BUSY_TIMEOUT;
  localparam int TMR_W  = $clog2(TMAX + 1);
  localparam int RATE_W = $clog2(RATE_DIV);
  localparam int BIT_W  = $clog2(FRAME_LEN) + 1;
  localparam logic [TMR_W-1:0]  CNV_LAST  = TMR_W'(CNV_HIGH - 1);
  localparam logic [TMR_W-1:0]  HALF_LAST = TMR_W'(SCK_HALF - 1);
  localparam logic [TMR_W-1:0]  WAIT_LAST = TMR_W'(BUSY_TIMEOUT - 1);
  localparam logic [RATE_W-1:0] RATE_LAST = RATE_W'(RATE_DIV - 1);
  localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(FRAME_LEN - 1);

  phase_t             state;
  logic [TMR_W-1:0]   tmr;
  logic [RATE_W-1:0]  rateCnt;
  logic [BIT_W-1:0]   bitIdx;
  logic               tick;
  logic               sdoMeta;
  logic               cnvQ;
  logic               sckQ;

  // rate divider: one tick per conversion slot
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rateCnt <= '0;
    else if (rateCnt == RATE_LAST) rateCnt <= '0;
    else rateCnt <= rateCnt + 1'b1;
  end
  assign tick = (rateCnt == RATE_LAST);

  // two-stage synchroniser on the converter data line (idles high)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdoMeta <= 1'b1;
      sdoLvl  <= 1'b1;
    end else begin
      sdoMeta <= sdoIn;
      sdoLvl  <= sdoMeta;
    end
  end

  always_comb begin
    strb           = '0;
    strb.loadCfg   = (state == ST_WAIT) && !sdoLvl;
    strb.resync    = (state == ST_WAIT) && sdoLvl && (tmr == WAIT_LAST);
    strb.sampleIn  = (state == ST_HIGH) && (tmr == HALF_LAST);
    strb.frameDone = strb.sampleIn && (bitIdx == BIT_LAST);
    strb.shiftOut  = strb.sampleIn && (bitIdx != BIT_LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      tmr        <= '0;
      bitIdx     <= '0;
      cnvQ       <= 1'b0;
      sckQ       <= 1'b0;
      timeoutErr <= 1'b0;
    end else begin
      timeoutErr <= strb.resync;
      case (state)
        ST_IDLE: begin
          if (tick) begin
            state <= ST_CNV;
            cnvQ  <= 1'b1;
            tmr   <= '0;
          end
        end
        ST_CNV: begin
          if (tmr == CNV_LAST) begin
            state <= ST_WAIT;
            cnvQ  <= 1'b0;
            tmr   <= '0;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_WAIT: begin
          if (strb.loadCfg) begin
            state  <= ST_LOW;
            tmr    <= '0;
            bitIdx <= '0;
          end else if (strb.resync) begin
            state <= ST_IDLE;
            tmr   <= '0;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_LOW: begin
          if (tmr == HALF_LAST) begin
            state <= ST_HIGH;
            sckQ  <= 1'b1;
            tmr   <= '0;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_HIGH: begin
          if (strb.sampleIn) begin
            sckQ <= 1'b0;
            tmr  <= '0;
            if (strb.frameDone) begin
              state <= ST_IDLE;
            end else begin
              state  <= ST_LOW;
              bitIdx <= bitIdx + 1'b1;
            end
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cnvOut = cnvQ;
  assign sckOut = sckQ;

  // ---------------- assertions ----------------
  logic [TMR_W:0]  cnvLen;
  logic [BIT_W:0]  riseCnt;
  logic            sckPrev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnvLen  <= '0;
      riseCnt <= '0;
      sckPrev <= 1'b0;
    end else begin
      cnvLen  <= cnvQ ? cnvLen + 1'b1 : '0;
      sckPrev <= sckQ;
      if (strb.loadCfg) riseCnt <= '0;
      else if (sckQ && !sckPrev) riseCnt <= riseCnt + 1'b1;
    end
  end

  AST_CNV_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cnvQ) |-> cnvLen == (TMR_W+1)'(CNV_HIGH)); // R1
  AST_SCK_QUIET_CNV: assert property (@(posedge clk) disable iff (!rst_n)
    cnvQ |-> !sckQ); // R2
  AST_SCK_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT) |-> !sckQ); // R2
  AST_FRAME_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    strb.frameDone |-> (riseCnt + (BIT_W+1)'(sckQ && !sckPrev)) == (BIT_W+1)'(FRAME_LEN)); // R3
  AST_TIMEOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    strb.resync |-> !sckQ && !cnvQ); // R8

endmodule

// File: rtl/adc_scan_dp.sv
module adc_scan_dp
  import adc_scan_pkg::*;
#(
  parameter int RES_W   = 16,
  parameter int NUM_CH  = 4,
  parameter bit BIPOLAR = 1'b0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  dpStrobe_t                 strb,
  input  logic                      sdoLvl,
  input  logic                      cfgWr,
  input  logic [CFG_W-1:0]          cfgData,
  output logic                      dinOut,
  output logic                      resValid,
  output logic [RES_W-1:0]          resData,
  output logic [$clog2(NUM_CH)-1:0] resChan
);

  localparam int CH_W  = $clog2(NUM_CH);
  localparam int PRIME = 2;   // frames of pipeline lag
  localparam logic [CH_W-1:0] CH_LAST = CH_W'(NUM_CH - 1);
  localparam logic [CFG_W-1:0] CFG_RST = resetCfg(BIPOLAR, 3'(NUM_CH - 1));

  logic [CFG_W-1:0] cfgReg;
  logic [CFG_W-1:0] txSh;
  logic [RES_W-1:0] rxSh;
  logic [RES_W-1:0] rxNext;
  logic [1:0]       primeCnt;
  logic [CH_W-1:0]  chanCnt;

  // stored configuration word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfgReg <= CFG_RST;
    else if (cfgWr) cfgReg <= cfgData;
  end

  // outgoing config shifter, MSB first, zero-filled after the word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) txSh <= '0;
    else if (strb.loadCfg) txSh <= cfgReg;
    else if (strb.shiftOut) txSh <= {txSh[CFG_W-2:0], 1'b0};
  end
  assign dinOut = txSh[CFG_W-1];

  // incoming result shifter; the busy bit falls off the top
  assign rxNext = {rxSh[RES_W-2:0], sdoLvl};
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rxSh <= '0;
    else if (strb.sampleIn) rxSh <= rxNext;
  end

  // pipeline priming and channel tagging
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primeCnt <= '0;
      chanCnt  <= '0;
      resValid <= 1'b0;
      resData  <= '0;
      resChan  <= '0;
    end else begin
      resValid <= 1'b0;
      if (strb.resync) begin
        primeCnt <= '0;
        chanCnt  <= '0;
      end else if (strb.frameDone) begin
        if (primeCnt == 2'(PRIME)) begin
          resValid <= 1'b1;
          resData  <= rxNext;
          resChan  <= chanCnt;
          chanCnt  <= (chanCnt == CH_LAST) ? '0 : chanCnt + 1'b1;
        end else begin
          primeCnt <= primeCnt + 1'b1;
        end
      end
    end
  end

  // ---------------- assertions ----------------
  logic            prevOk;
  logic [CH_W-1:0] prevChan;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevOk   <= 1'b0;
      prevChan <= '0;
    end else if (strb.resync) begin
      prevOk <= 1'b0;
    end else if (resValid) begin
      prevOk   <= 1'b1;
      prevChan <= resChan;
    end
  end

  AST_PRIME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.frameDone && primeCnt != 2'(PRIME)) |=> !resValid); // R6
  AST_CHAN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (resValid && prevOk) |-> resChan == ((prevChan == CH_LAST) ? '0 : prevChan + 1'b1)); // R7
  AST_CHAN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (resValid && !prevOk) |-> resChan == '0); // R8

endmodule

// File: rtl/adc_scan_host.sv
module adc_scan_host
  import adc_scan_pkg::*;
#(
  parameter int CLK_HZ       = 250_000_000,
  parameter int SAMPLE_HZ    = 800,
  parameter int NUM_CH       = 4,
  parameter int RES_W        = 16,
  parameter int CNV_HIGH     = 3,
  parameter int SCK_HALF     = 3,
  parameter int BUSY_TIMEOUT = 2000,
  parameter bit BIPOLAR      = 1'b0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfgWr,
  input  logic [13:0]               cfgData,
  input  logic                      adcSdo,
  output logic                      adcCnv,
  output logic                      adcSck,
  output logic                      adcDin,
  output logic                      resValid,
  output logic [RES_W-1:0]          resData,
  output logic [$clog2(NUM_CH)-1:0] resChan,
  output logic                      timeoutErr
);

  localparam int RATE_DIV  = CLK_HZ / (SAMPLE_HZ * NUM_CH);
  localparam int FRAME_LEN = RES_W + 1;

  dpStrobe_t strb;
  logic      sdoLvl;

  adc_scan_ctrl #(
    .RATE_DIV    (RATE_DIV),
    .CNV_HIGH    (CNV_HIGH),
    .SCK_HALF    (SCK_HALF),
    .BUSY_TIMEOUT(BUSY_TIMEOUT),
    .FRAME_LEN   (FRAME_LEN)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .sdoIn     (adcSdo),
    .cnvOut    (adcCnv),
    .sckOut    (adcSck),
    .sdoLvl    (sdoLvl),
    .timeoutErr(timeoutErr),
    .strb      (strb)
  );

  adc_scan_dp #(
    .RES_W  (RES_W),
    .NUM_CH (NUM_CH),
    .BIPOLAR(BIPOLAR)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strb),
    .sdoLvl  (sdoLvl),
    .cfgWr   (cfgWr),
    .cfgData (cfgData),
    .dinOut  (adcDin),
    .resValid(resValid),
    .resData (resData),
    .resChan (resChan)
  );

endmodule

// File: tb/adc_scan_host_bench.sv
`timescale 1ns/1ps
module adc_scan_host_bench;

  localparam int RATE = 200;
  localparam int CNVW = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfgWr = 1'b0;
  logic [13:0] cfgData = '0;
  logic        adcSdo = 1'b1;
  logic        adcCnv, adcSck, adcDin, resValid, timeoutErr;
  logic [15:0] resData;
  logic [1:0]  resChan;

  always #2 clk = ~clk;

  adc_scan_host #(
    .CLK_HZ(640_000), .SAMPLE_HZ(800), .NUM_CH(4), .RES_W(16),
    .CNV_HIGH(CNVW), .SCK_HALF(3), .BUSY_TIMEOUT(60), .BIPOLAR(1'b0)
  ) u_adc_scan_host (
    .clk(clk), .rst_n(rst_n), .cfgWr(cfgWr), .cfgData(cfgData),
    .adcSdo(adcSdo), .adcCnv(adcCnv), .adcSck(adcSck), .adcDin(adcDin),
    .resValid(resValid), .resData(resData), .resChan(resChan),
    .timeoutErr(timeoutErr)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int convCnt = 0;
  int outCnt = 0;
  int pushCnt = 0;
  int toCnt = 0;
  int primeLeft = 2;
  int expChan = 0;
  logic [13:0] expCfg = 14'h39BE;
  bit dropReq = 1'b0;
  bit curDropped = 1'b0;
  bit busyShown = 1'b0;
  bit earlySck = 1'b0;
  int sckRise = 0;
  logic [15:0] qData[$];
  int qChan[$];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int nextChan(input int c);
    return (c + 1) % 4;
  endfunction

  always @(posedge clk) cyc++;
  always @(posedge adcSck) sckRise++;

  // sck before busy-low or during the convert pulse
  always @(negedge clk)
    if (rst_n && adcSck && (adcCnv || !busyShown)) earlySck = 1'b1;

  // convert pulse width, spacing, per-frame sck count and quiet check
  initial begin
    int lastRise;
    int w;
    lastRise = -1;
    forever begin
      @(posedge adcCnv);
      if (lastRise >= 0) begin
        check(cyc - lastRise == RATE, "R1", "convert spacing", cyc - lastRise, RATE);
        check(sckRise == (curDropped ? 0 : 17), "R3", "sck rises per frame",
              sckRise, curDropped ? 0 : 17);
        check(!earlySck, "R2", "sck before busy-low", earlySck, 0);
      end
      lastRise = cyc;
      sckRise  = 0;
      earlySck = 1'b0;
      w = 0;
      forever begin
        @(negedge clk);
        if (adcCnv) w++;
        else break;
      end
      check(w == CNVW, "R1", "convert width", w, CNVW);
    end
  end

  // converter model
  initial begin
    logic [15:0] word;
    logic [13:0] rxCfg;
    int dly;
    bit zeroTail;
    forever begin
      @(posedge adcCnv);
      #1;
      adcSdo = 1'b1;
      busyShown = 1'b0;
      convCnt++;
      curDropped = dropReq;
      @(negedge adcCnv);
      if (dropReq) begin
        dropReq = 1'b0;
        primeLeft = 2;
        expChan = 0;
        continue;
      end
      dly = 4 + int'($urandom % 30);
      repeat (dly) @(posedge clk);
      #1;
      adcSdo = 1'b0;
      busyShown = 1'b1;
      word = 16'($urandom);
      zeroTail = 1'b1;
      for (int b = 0; b < 17; b++) begin
        @(posedge adcSck);
        if (b < 14) rxCfg[13-b] = adcDin;
        else if (adcDin) zeroTail = 1'b0;
        @(negedge adcSck);
        #1;
        if (b < 16) adcSdo = word[15-b];
      end
      check(rxCfg == expCfg, "R4/R5", "config word", rxCfg, expCfg);
      check(zeroTail, "R4", "din tail zero", zeroTail, 1);
      if (primeLeft > 0) primeLeft--;
      else begin
        qData.push_back(word);
        qChan.push_back(expChan);
        expChan = nextChan(expChan);
        pushCnt++;
      end
    end
  end

  // result monitor
  always @(negedge clk) begin
    if (rst_n && timeoutErr) toCnt++;
    if (rst_n && resValid) begin
      outCnt++;
      if (qData.size() == 0) begin
        check(1'b0, "R6", "unexpected result", resData, 0);
      end else begin
        logic [15:0] d;
        int c;
        d = qData.pop_front();
        c = qChan.pop_front();
        check(resData == d, "R3", "result data", resData, d);
        check(int'(resChan) == c, "R7", "channel tag", resChan, c);
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    check({adcCnv, adcSck, adcDin, resValid, timeoutErr} == 5'b0, "R9", "in reset",
          {adcCnv, adcSck, adcDin, resValid, timeoutErr}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({adcCnv, adcSck, adcDin, resValid, timeoutErr} == 5'b0, "R9", "after reset",
          {adcCnv, adcSck, adcDin, resValid, timeoutErr}, 0);

    wait (convCnt >= 12);
    // R5: new config word loaded between frames
    @(posedge resValid);
    @(negedge clk);
    cfgData = 14'($urandom);
    cfgWr   = 1'b1;
    expCfg  = cfgData;
    @(negedge clk);
    cfgWr   = 1'b0;
    cfgData = 14'h0;
    wait (convCnt >= 20);

    // directed corner: converter never answers once (R8)
    @(posedge resValid);
    @(negedge clk);
    dropReq = 1'b1;
    wait (convCnt >= 34);
    @(posedge adcCnv);
    repeat (5) @(negedge clk);

    check(toCnt == 1, "R8", "timeout pulses", toCnt, 1);
    check(outCnt == pushCnt && qData.size() == 0, "R6", "results vs frames", outCnt, pushCnt);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule